// File: doc/BRIEF.md
# BT.656 Stream Formatter

This block turns a 4:2:2 picture stream (one luma bus, one chroma bus carrying Cb and Cr in turn) into a single 10-bit word stream. It runs at twice the pixel rate and follows the BT.656 convention. The block keeps its own line timebase, which has a word counter and a selectable line standard. Each line starts with an end-of-active-video code. Next come blanking fill words and a start-of-active-video code, and then 1440 words of multiplexed picture data. Upstream logic holds each sample on the inputs until the block takes it, in the word slot the timebase sets.

The line standard (525-line or 625-line) sets how long the blanking interval is. The vertical-valid and field inputs are encoded into the protection word that ends each timing code. All three inputs are captured once per line, on the last word of the line, so a whole line uses one consistent set of values. The horizontal-valid input qualifies the picture words. Where it is low inside the active region, the block sends blanking fill instead of sample data. A one-cycle start-of-line pulse marks the first word of every line for whatever checks or follows the stream.

Top module: `bt656_fmt`

## Requirements
- R1: A line is 1716 words long when `pal_mode`=0 and 1728 words when `pal_mode`=1. `sol_out` is high for exactly one cycle per line, on the cycle that shows word 0.
- R2: Every timing code is four words: 3FFh, 000h, 000h, then a protection word. The end-of-active code takes words 0..3. The start-of-active code takes words 272..275 (525-line) or 284..287 (625-line).
- R3: The protection word has these bits: bit9=1, bit8=F, bit7=V, bit6=H, bit5=V^H, bit4=F^H, bit3=F^V, bit2=F^V^H, bits1:0=0. H=1 in the end-of-active code and H=0 in the start-of-active code.
- R4: F equals `field_id` and V equals the inverse of `v_act`. Both are sampled on the clock edge that emits the last word of the previous line and hold for the whole line.
- R5: The blanking words between the two codes carry fill: 200h at even word positions and 040h at odd ones. Inputs have no effect there.
- R6: The active region is words 276..1715 (525-line) or 288..1727 (625-line). With active index a counted from 0, words with a mod 4 = 0 or 2 carry `chroma_in` (Cb, then Cr) and odd words carry `luma_in`. Each word shows the input value present at the clock edge that emits it.
- R7: In the active region, a word whose emitting edge sees `h_act`=0 is replaced by fill: 200h on chroma positions and 040h on luma positions.
- R8: A change of `pal_mode` takes effect from the next line start. The line in progress keeps its length.
- R9: While `rst` is high, `word_out` is 000h and `sol_out` is 0. The first edge after `rst` is released emits word 0 of a line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock (twice the pixel rate) |
| rst | input | 1 | Synchronous reset, active high |
| pal_mode | input | 1 | Line standard: 0 = 525-line, 1 = 625-line |
| h_act | input | 1 | Horizontal valid; low masks active words with fill |
| v_act | input | 1 | Vertical valid; its inverse is coded as V |
| field_id | input | 1 | Field flag, coded as F |
| luma_in | input | 10 | Luma sample |
| chroma_in | input | 10 | Chroma sample (Cb and Cr alternately) |
| word_out | output | 10 | Multiplexed BT.656 word stream |
| sol_out | output | 1 | Start-of-line pulse, high with word 0 |

## Verification
Two actions fall on the same clock edge. The last active sample of a line is registered out, and the line-control capture takes `pal_mode`, `v_act` and `field_id` for the next line. The bench changes these inputs partway through a line and then checks two things. The captured line must keep its own length and picture data. The line that follows must carry the new length and the new F and V bits in both of its protection words. Separately, masking windows are placed on the first and the last active words, so that the fill substitution meets the boundary with the start-of-active code and with the wrap to word 0.

// File: rtl/bt656_fmt_pkg.sv
package bt656_fmt_pkg;

    localparam int WORD_W       = 10;
    localparam int ACT_WORDS_D  = 1440;
    localparam int BLANK_525_D  = 276;
    localparam int BLANK_625_D  = 288;
    localparam int CODE_LEN     = 4;

    typedef logic [WORD_W-1:0] word_t;

    localparam word_t FILL_CHROMA = 10'h200;
    localparam word_t FILL_LUMA   = 10'h040;
    localparam word_t CODE_ONES   = 10'h3FF;
    localparam word_t CODE_ZEROS  = 10'h000;

    typedef enum logic [1:0] {
        RG_EAV  = 2'd0,
        RG_FILL = 2'd1,
        RG_SAV  = 2'd2,
        RG_ACT  = 2'd3
    } region_e;

    typedef struct packed {
        region_e    rg;
        logic [1:0] ph;
        logic       fbit;
        logic       vbit;
        logic       first;
    } line_ctx_t;

    function automatic word_t xy_word(input logic f, input logic v, input logic h);
        xy_word = {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h, 2'b00};
    endfunction

endpackage

// File: rtl/bt656_timebase.sv
module bt656_timebase
    import bt656_fmt_pkg::*;
#(
    parameter int ACT_WORDS = ACT_WORDS_D,
    parameter int BLANK_A   = BLANK_525_D,
    parameter int BLANK_B   = BLANK_625_D
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      pal_mode,
    input  logic      v_act,
    input  logic      field_id,
    output line_ctx_t ctx
);
    localparam int TOT_MAX = ((BLANK_A > BLANK_B) ? BLANK_A : BLANK_B) + ACT_WORDS;
    localparam int CW      = $clog2(TOT_MAX + 1);
    localparam logic [CW-1:0] BLK_A_C = CW'(BLANK_A);
    localparam logic [CW-1:0] BLK_B_C = CW'(BLANK_B);
    localparam logic [CW-1:0] ACT_C   = CW'(ACT_WORDS);
    localparam logic [CW-1:0] CODE_C  = CW'(CODE_LEN);

    logic [CW-1:0] cnt;
    logic          std_q;
    logic          v_q;
    logic          f_q;
    logic [CW-1:0] blank_len;
    logic [CW-1:0] last_idx;

    assign blank_len = std_q ? BLK_B_C : BLK_A_C;
    assign last_idx  = blank_len + ACT_C - CW'(1);

    // Line controls are captured on the edge that emits the final word.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            std_q <= pal_mode;
            v_q   <= ~v_act;
            f_q   <= field_id;
        end else if (cnt == last_idx) begin
            cnt   <= '0;
            std_q <= pal_mode;
            v_q   <= ~v_act;
            f_q   <= field_id;
        end else begin
            cnt   <= cnt + CW'(1);
        end
    end

    // Blank length is a multiple of four, so the low count bits give the
    // phase inside each code and inside each Cb/Y/Cr/Y group.
    always_comb begin
        if (cnt < CODE_C)
            ctx.rg = RG_EAV;
        else if (cnt < blank_len - CODE_C)
            ctx.rg = RG_FILL;
        else if (cnt < blank_len)
            ctx.rg = RG_SAV;
        else
            ctx.rg = RG_ACT;
        ctx.ph    = cnt[1:0];
        ctx.fbit  = f_q;
        ctx.vbit  = v_q;
        ctx.first = (cnt == '0);
    end

endmodule

// File: rtl/bt656_word_mux.sv
module bt656_word_mux
    import bt656_fmt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  line_ctx_t ctx,
    input  logic      h_act,
    input  word_t     luma_in,
    input  word_t     chroma_in,
    output word_t     word_out,
    output logic      sol_out
);
    word_t nxt;
    word_t fill_w;

    assign fill_w = ctx.ph[0] ? FILL_LUMA : FILL_CHROMA;

    always_comb begin
        case (ctx.rg)
            RG_EAV, RG_SAV: begin
                case (ctx.ph)
                    2'd0:    nxt = CODE_ONES;
                    2'd3:    nxt = xy_word(ctx.fbit, ctx.vbit, ctx.rg == RG_EAV);
                    default: nxt = CODE_ZEROS;
                endcase
            end
            RG_FILL: nxt = fill_w;
            default: begin
                if (!h_act)
                    nxt = fill_w;
                else
                    nxt = ctx.ph[0] ? luma_in : chroma_in;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_out <= '0;
            sol_out  <= 1'b0;
        end else begin
            word_out <= nxt;
            sol_out  <= ctx.first;
        end
    end

endmodule

// File: rtl/bt656_fmt.sv
module bt656_fmt
    import bt656_fmt_pkg::*;
#(
    parameter int ACT_WORDS = ACT_WORDS_D,
    parameter int BLANK_A   = BLANK_525_D,
    parameter int BLANK_B   = BLANK_625_D
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        pal_mode,
    input  logic        h_act,
    input  logic        v_act,
    input  logic        field_id,
    input  logic [9:0]  luma_in,
    input  logic [9:0]  chroma_in,
    output logic [9:0]  word_out,
    output logic        sol_out
);
    line_ctx_t ctx;

    bt656_timebase #(
        .ACT_WORDS (ACT_WORDS),
        .BLANK_A   (BLANK_A),
        .BLANK_B   (BLANK_B)
    ) tb_i (
        .clk      (clk),
        .rst      (rst),
        .pal_mode (pal_mode),
        .v_act    (v_act),
        .field_id (field_id),
        .ctx      (ctx)
    );

    bt656_word_mux mux_i (
        .clk       (clk),
        .rst       (rst),
        .ctx       (ctx),
        .h_act     (h_act),
        .luma_in   (luma_in),
        .chroma_in (chroma_in),
        .word_out  (word_out),
        .sol_out   (sol_out)
    );

endmodule

// File: rtl/bt656_fmt_chk.sv
module bt656_fmt_chk
    import bt656_fmt_pkg::*;
#(
    parameter int TOT_A = BLANK_525_D + ACT_WORDS_D,
    parameter int TOT_B = BLANK_625_D + ACT_WORDS_D
) (
    input logic       clk,
    input logic       rst,
    input logic [9:0] word_out,
    input logic       sol_out
);
    logic [11:0] pos;
    logic        seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos  <= '0;
            seen <= 1'b0;
        end else if (sol_out) begin
            pos  <= 12'd1;
            seen <= 1'b1;
        end else if (pos != 12'hFFF) begin
            pos  <= pos + 12'd1;
        end
    end

    AST_SOL_SINGLE: assert property (@(posedge clk) disable iff (rst)
        sol_out |=> !sol_out); // R1

    AST_LINE_SPACING: assert property (@(posedge clk) disable iff (rst)
        (sol_out && seen) |-> (pos == 12'(TOT_A) || pos == 12'(TOT_B))); // R1

    AST_EAV_LEAD: assert property (@(posedge clk) disable iff (rst)
        sol_out |-> (word_out == 10'h3FF)); // R2

    AST_EAV_ZERO: assert property (@(posedge clk) disable iff (rst)
        sol_out |=> (word_out == 10'h000)); // R2

    AST_XY_FORM: assert property (@(posedge clk) disable iff (rst)
        (seen && pos == 12'd3) |-> (word_out[9] && word_out[6] &&
            word_out[1:0] == 2'b00 &&
            word_out[5] == (word_out[7] ^ word_out[6]) &&
            word_out[4] == (word_out[8] ^ word_out[6]) &&
            word_out[3] == (word_out[8] ^ word_out[7]) &&
            word_out[2] == (word_out[8] ^ word_out[7] ^ word_out[6]))); // R3

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (word_out == 10'h000 && !sol_out)); // R9

endmodule

bind bt656_fmt bt656_fmt_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .word_out (word_out),
    .sol_out  (sol_out)
);

// File: tb/bt656_fmt_tb.sv
module bt656_fmt_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pal_mode = 1'b0;
    logic       h_act = 1'b0;
    logic       v_act = 1'b0;
    logic       field_id = 1'b0;
    logic [9:0] luma_in = '0;
    logic [9:0] chroma_in = '0;
    logic [9:0] word_out;
    logic       sol_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    bt656_fmt dut_i (
        .clk       (clk),
        .rst       (rst),
        .pal_mode  (pal_mode),
        .h_act     (h_act),
        .v_act     (v_act),
        .field_id  (field_id),
        .luma_in   (luma_in),
        .chroma_in (chroma_in),
        .word_out  (word_out),
        .sol_out   (sol_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp_v);
        end
    endtask

    task automatic wait_sol();
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!sol_out && n < 4000);
        check(sol_out, "R1 start-of-line not seen", 0, 1);
    endtask

    function automatic logic [9:0] fill_of(input int p);
        return (p % 2 == 1) ? 10'h040 : 10'h200;
    endfunction

    function automatic logic [9:0] xy_of(input bit f, input bit v, input bit h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h, 2'b00};
    endfunction

    // Capture the next full line and compare each word with the expected stream.
    task automatic grab_line(input string name, input bit pal, input bit va, input bit fl,
                             input int glo, input int ghi, input int seed);
        int blank = pal ? 288 : 276;
        int tot   = blank + 1440;
        bit vb    = ~va;
        logic [9:0] dy [0:1727];
        logic [9:0] dc [0:1727];
        bit         dh [0:1727];
        int bad_code = 0, bad_xy = 0, bad_flag = 0, bad_fill = 0, bad_act = 0, bad_mask = 0, bad_sol = 0;
        int a_code = 0, e_code = 0, a_xy = 0, e_xy = 0, a_fill = 0, e_fill = 0;
        int a_act = 0, e_act = 0, a_mask = 0, e_mask = 0;
        bit any_mask = 1'b0;
        wait_sol();
        for (int p = 0; p <= tot; p++) begin
            if (p == tot) begin
                check(sol_out == 1'b1, {"R1 line length ", name}, int'(sol_out), 1);
                check(word_out == 10'h3FF, {"R2 next line lead ", name}, int'(word_out), 10'h3FF);
            end else begin
                logic [9:0] exp_w;
                int a = p - blank;
                if (p > 0 && sol_out) bad_sol++;
                if (p < 4 || (p >= blank - 4 && p < blank)) begin
                    int k = (p < 4) ? p : p - (blank - 4);
                    bit h = (p < 4);
                    exp_w = (k == 0) ? 10'h3FF : (k == 3) ? xy_of(fl, vb, h) : 10'h000;
                    if (k == 3) begin
                        if (word_out[8] != fl || word_out[7] != vb) bad_flag++;
                        if (word_out != exp_w) begin
                            if (bad_xy == 0) begin a_xy = int'(word_out); e_xy = int'(exp_w); end
                            bad_xy++;
                        end
                    end else if (word_out != exp_w) begin
                        if (bad_code == 0) begin a_code = int'(word_out); e_code = int'(exp_w); end
                        bad_code++;
                    end
                end else if (p < blank) begin
                    exp_w = fill_of(p);
                    if (word_out != exp_w) begin
                        if (bad_fill == 0) begin a_fill = int'(word_out); e_fill = int'(exp_w); end
                        bad_fill++;
                    end
                end else if (!dh[p-1]) begin
                    any_mask = 1'b1;
                    exp_w = fill_of(a);
                    if (word_out != exp_w) begin
                        if (bad_mask == 0) begin a_mask = int'(word_out); e_mask = int'(exp_w); end
                        bad_mask++;
                    end
                end else begin
                    exp_w = (a % 2 == 1) ? dy[p-1] : dc[p-1];
                    if (word_out != exp_w) begin
                        if (bad_act == 0) begin a_act = int'(word_out); e_act = int'(exp_w); end
                        bad_act++;
                    end
                end
            end
            if (p < tot) begin
                int q = p + 1;
                dy[p] = 10'((q * 7 + seed) & 10'h3FF);
                dc[p] = 10'((q * 13 + seed * 3) & 10'h3FF);
                if (q >= blank)
                    dh[p] = !((q - blank) >= glo && (q - blank) < ghi);
                else
                    dh[p] = (q % 3 == 0);
                luma_in   = dy[p];
                chroma_in = dc[p];
                h_act     = dh[p];
                @(negedge clk);
            end
        end
        check(bad_sol == 0, {"R1 single pulse ", name}, bad_sol, 0);
        check(bad_code == 0, {"R2 code words ", name}, a_code, e_code);
        check(bad_xy == 0, {"R3 protection word ", name}, a_xy, e_xy);
        check(bad_flag == 0, {"R4 F/V bits ", name}, bad_flag, 0);
        check(bad_fill == 0, {"R5 blank fill ", name}, a_fill, e_fill);
        check(bad_act == 0, {"R6 active order ", name}, a_act, e_act);
        if (any_mask)
            check(bad_mask == 0, {"R7 masked fill ", name}, a_mask, e_mask);
    endtask

    task automatic test_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(word_out == 10'h000, "R9 reset word", int'(word_out), 0);
        check(sol_out == 1'b0, "R9 reset sol", int'(sol_out), 0);
        rst = 1'b0;
        @(negedge clk);
        check(sol_out == 1'b1, "R9 first word after reset", int'(sol_out), 1);
        check(word_out == 10'h3FF, "R9 first word value", int'(word_out), 10'h3FF);
    endtask

    task automatic test_line(input string name, input bit pal, input bit va, input bit fl,
                             input int glo, input int ghi, input int seed);
        pal_mode = pal;
        v_act    = va;
        field_id = fl;
        wait_sol();
        grab_line(name, pal, va, fl, glo, ghi, seed);
    endtask

    // R8: switch the standard mid-line; the running line keeps its length.
    task automatic test_switch();
        int n = 0;
        pal_mode = 1'b0;
        wait_sol();
        wait_sol();
        repeat (600) @(negedge clk);
        pal_mode = 1'b1;
        n = 600;
        do begin
            @(negedge clk);
            n++;
        end while (!sol_out && n < 4000);
        check(n == 1716, "R8 running line unchanged", n, 1716);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!sol_out && n < 4000);
        check(n == 1728, "R8 next line new length", n, 1728);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog act=hung exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        test_reset();
        test_line("525 nogap", 1'b0, 1'b1, 1'b0, 2000, 2000, 5);
        test_line("625 nogap", 1'b1, 1'b0, 1'b1, 2000, 2000, 17);
        test_line("625 midgap", 1'b1, 1'b1, 1'b1, 100, 140, 33);
        test_line("525 startgap", 1'b0, 1'b0, 1'b0, 0, 3, 71);
        test_line("525 endgap", 1'b0, 1'b1, 1'b1, 1436, 1440, 90);
        test_switch();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule